// File: doc/BRIEF.md
# Symmetric Up/Down PWM Timer with Buffered Compare

This block is a 16-bit triangle-wave timer that produces center-aligned pulse-width modulation on a set of compare outputs. Its counter climbs from zero to a turning value (TOP), then descends back to zero, and repeats. The counter moves by one only when an external prescaler pulses `tick`, so the output period is 2·TOP ticks.

Software-side values (TOP and one compare value per channel) are written into shadow buffers. They are copied into the active registers only at a turning point. `load_at_bottom` selects whether the copy happens as the counter leaves TOP or as it leaves zero. TOP can come from its own register or from channel A's compare value. Each channel has a two-bit output-mode field: hold, toggle, non-inverting or inverting.

The counter is a three-state machine. IDLE is the state after reset, and the count sits at 0 while the active registers follow the buffers. On the first tick it moves IDLE→UP. On a tick in UP with the count at or above TOP it moves UP→DOWN. On a tick in DOWN with the count at 0 it moves DOWN→UP.

Top module: `sympwm_timer`

## Requirements
- R1: Each `tick` moves the count by exactly one, and the count stays unchanged without a tick. Starting from reset, the count follows 0,1,…,TOP,TOP−1,…,0,1,… and each value lasts one tick, so one period is 2·TOP ticks.
- R2: With mode field value 2 (non-inverting), an output goes low when the count arrives at its compare value C while rising, and goes high when the count arrives at C while falling. It is high for 2·C ticks of each period.
- R3: With mode field value 3 (inverting), the levels of R2 are swapped, so the output is high for 2·(TOP−C) ticks of each period.
- R4: Compare value 0 keeps a non-inverting output low and an inverting output high. A compare value at or above TOP keeps a non-inverting output high and an inverting output low.
- R5: A write with `wr_sel`=0 targets the TOP buffer and `wr_sel`=k targets channel k−1's compare buffer. Any other `wr_sel` value is ignored. A buffered value has no effect until the next load.
- R6: With `load_at_bottom`=0, the buffers load on the tick that leaves TOP.
- R7: With `load_at_bottom`=1, the buffers load on the tick that leaves 0. Rising and falling slopes within one period are therefore always equal.
- R8: With `top_from_a`=1, the effective TOP is channel A's active compare value. Otherwise it is the active TOP register. In both cases a value below 3 is raised to 3.
- R9: Mode field value 1 on channel A with `top_from_a`=1 inverts the output each time the count arrives at TOP. Mode field value 1 in any other case, and mode field value 0 always, hold the output at its last level.
- R10: `at_top` pulses for one cycle when the count arrives at TOP. `at_bottom` pulses for one cycle when the count arrives at 0 while falling.
- R11: After reset the count, outputs and flags are 0. Until the first tick the active registers copy the buffers on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable from the prescaler |
| wr_en | input | 1 | Buffer write strobe |
| wr_sel | input | SELW (2) | Buffer select: 0 TOP, k compare of channel k−1 |
| wr_data | input | W (16) | Value to write |
| load_at_bottom | input | 1 | 0: load leaving TOP, 1: load leaving zero |
| top_from_a | input | 1 | Take TOP from channel A's compare value |
| out_mode | input | 2·NCH (4) | Two-bit mode per channel, channel k at bits [2k+1:2k] |
| pwm_out | output | NCH (2) | Compare outputs |
| count | output | W (16) | Counter value |
| at_top | output | 1 | Arrival-at-TOP pulse |
| at_bottom | output | 1 | Arrival-at-zero pulse |

## Verification
The bench changes TOP in mid-slope under both load points. A design that loads at the wrong turning point shows the new peak one half-period early or late, and its slopes come out lopsided. It drives compare values of 0, TOP and above TOP, where a design that only reacts to matches would let the output drift. It runs toggle mode with channel A setting TOP, where a wrong direction qualifier would toggle twice per period. It also checks that mode 0 and gated ticks freeze the outputs and the count instead of letting them creep.

// File: rtl/sympwm_pkg.sv
package sympwm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } cnt_state_e;

    typedef enum logic [1:0] {
        OM_HOLD   = 2'd0,
        OM_TOGGLE = 2'd1,
        OM_NONINV = 2'd2,
        OM_INV    = 2'd3
    } out_mode_e;

    localparam int unsigned TOP_FLOOR = 3;
endpackage

// File: rtl/sympwm_counter.sv
module sympwm_counter
    import sympwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] top_eff,
    input  logic         load_at_bottom,
    output logic [W-1:0] count,
    output logic [W-1:0] step_val,
    output logic         step_up,
    output logic         load_now,
    output logic         idle,
    output logic         at_top,
    output logic         at_bottom
);
    cnt_state_e   state_q, state_d;
    logic [W-1:0] cnt_q;

    // Next-state and next-count decision
    always_comb begin
        state_d  = state_q;
        step_val = cnt_q;
        step_up  = 1'b1;
        load_now = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                step_val = {{(W-1){1'b0}}, 1'b1};
                step_up  = 1'b1;
                state_d  = ST_UP;
            end
            ST_UP: begin
                if (cnt_q >= top_eff) begin
                    step_val = cnt_q - 1'b1;
                    step_up  = 1'b0;
                    state_d  = ST_DOWN;
                    load_now = tick && !load_at_bottom;
                end else begin
                    step_val = cnt_q + 1'b1;
                    step_up  = 1'b1;
                end
            end
            ST_DOWN: begin
                if (cnt_q == '0) begin
                    step_val = {{(W-1){1'b0}}, 1'b1};
                    step_up  = 1'b1;
                    state_d  = ST_UP;
                    load_now = tick && load_at_bottom;
                end else begin
                    step_val = cnt_q - 1'b1;
                    step_up  = 1'b0;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (tick) begin
            state_q <= state_d;
            cnt_q   <= step_val;
        end
    end

    // Output flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            at_top    <= 1'b0;
            at_bottom <= 1'b0;
        end else begin
            at_top    <= tick && step_up && (step_val == top_eff);
            at_bottom <= tick && !step_up && (step_val == '0);
        end
    end

    assign count = cnt_q;
    assign idle  = (state_q == ST_IDLE);

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state_q != ST_IDLE) |=> (count == $past(count) + 1 || count == $past(count) - 1)); // R1
    AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count)); // R1
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(at_top && at_bottom)); // R10
    AST_TOP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        at_top |=> !at_top); // R10
endmodule

// File: rtl/sympwm_regs.sv
module sympwm_regs
    import sympwm_pkg::*;
#(
    parameter int          W       = 16,
    parameter int          NCH     = 2,
    parameter int          SELW    = 2,
    parameter logic [W-1:0] TOP_RST = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SELW-1:0]       wr_sel,
    input  logic [W-1:0]          wr_data,
    input  logic                  load_en,
    input  logic                  top_from_a,
    output logic [W-1:0]          top_eff,
    output logic [NCH-1:0][W-1:0] cmp_act
);
    logic [W-1:0]          top_buf, top_act, top_src;
    logic [NCH-1:0][W-1:0] cmp_buf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_buf <= TOP_RST;
            top_act <= TOP_RST;
        end else begin
            if (wr_en && wr_sel == '0) top_buf <= wr_data;
            if (load_en) top_act <= top_buf;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_buf[g] <= '0;
                cmp_act[g] <= '0;
            end else begin
                if (wr_en && wr_sel == SELW'(g + 1)) cmp_buf[g] <= wr_data;
                if (load_en) cmp_act[g] <= cmp_buf[g];
            end
        end
    end

    assign top_src = top_from_a ? cmp_act[0] : top_act;
    assign top_eff = (top_src < W'(TOP_FLOOR)) ? W'(TOP_FLOOR) : top_src;

    AST_TOP_HELD_UNTIL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(top_act)); // R5
    AST_CMPA_HELD_UNTIL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(cmp_act[0])); // R5
    AST_TOP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        top_eff >= W'(TOP_FLOOR)); // R8
endmodule

// File: rtl/sympwm_channel.sv
module sympwm_channel
    import sympwm_pkg::*;
#(
    parameter int W    = 16,
    parameter int IS_A = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] step_val,
    input  logic         step_up,
    input  logic [W-1:0] cmp,
    input  logic [W-1:0] top_eff,
    input  logic [1:0]   mode,
    input  logic         top_from_a,
    output logic         pwm
);
    out_mode_e md;
    logic      hit, tgl_ok, pwm_d;

    assign md     = out_mode_e'(mode);
    assign hit    = (step_val == cmp);
    assign tgl_ok = (IS_A != 0) && top_from_a;

    always_comb begin
        pwm_d = pwm;
        unique case (md)
            OM_HOLD:   pwm_d = pwm;
            OM_TOGGLE: if (tgl_ok && step_up && hit) pwm_d = ~pwm;
            OM_NONINV: begin
                if (cmp == '0)             pwm_d = 1'b0;
                else if (cmp >= top_eff)   pwm_d = 1'b1;
                else if (hit)              pwm_d = ~step_up;
            end
            OM_INV: begin
                if (cmp == '0)             pwm_d = 1'b1;
                else if (cmp >= top_eff)   pwm_d = 1'b0;
                else if (hit)              pwm_d = step_up;
            end
            default: pwm_d = pwm;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pwm <= 1'b0;
        else if (step) pwm <= pwm_d;
    end

    AST_HOLD_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && md == OM_HOLD) |=> $stable(pwm)); // R9
    AST_ZERO_CMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (step && md == OM_NONINV && cmp == '0) |=> !pwm); // R4
    AST_ZERO_CMP_INV_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (step && md == OM_INV && cmp == '0) |=> pwm); // R4
endmodule

// File: rtl/sympwm_timer.sv
module sympwm_timer
    import sympwm_pkg::*;
#(
    parameter int           W       = 16,
    parameter int           NCH     = 2,
    parameter logic [W-1:0] TOP_RST = '1,
    localparam int          SELW    = $clog2(NCH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [SELW-1:0]   wr_sel,
    input  logic [W-1:0]      wr_data,
    input  logic              load_at_bottom,
    input  logic              top_from_a,
    input  logic [2*NCH-1:0]  out_mode,
    output logic [NCH-1:0]    pwm_out,
    output logic [W-1:0]      count,
    output logic              at_top,
    output logic              at_bottom
);
    logic [W-1:0]          top_eff, step_val;
    logic [NCH-1:0][W-1:0] cmp_act;
    logic                  step_up, load_now, idle;

    sympwm_counter #(.W(W)) u_counter (
        .clk(clk), .rst_n(rst_n), .tick(tick), .top_eff(top_eff),
        .load_at_bottom(load_at_bottom), .count(count), .step_val(step_val),
        .step_up(step_up), .load_now(load_now), .idle(idle),
        .at_top(at_top), .at_bottom(at_bottom)
    );

    sympwm_regs #(.W(W), .NCH(NCH), .SELW(SELW), .TOP_RST(TOP_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .load_en(load_now || idle), .top_from_a(top_from_a),
        .top_eff(top_eff), .cmp_act(cmp_act)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        sympwm_channel #(.W(W), .IS_A(c == 0 ? 1 : 0)) u_ch (
            .clk(clk), .rst_n(rst_n), .step(tick), .step_val(step_val),
            .step_up(step_up), .cmp(cmp_act[c]), .top_eff(top_eff),
            .mode(out_mode[2*c +: 2]), .top_from_a(top_from_a), .pwm(pwm_out[c])
        );
    end

    AST_COUNT_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !tick) |=> count == '0); // R11
endmodule

// File: tb/sympwm_timer_bench.sv
module sympwm_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n, tick, wr_en, load_at_bottom, top_from_a;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic [3:0]  out_mode;
    logic [1:0]  pwm_out;
    logic [15:0] count;
    logic        at_top, at_bottom;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sympwm_timer u_sympwm_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .load_at_bottom(load_at_bottom), .top_from_a(top_from_a),
        .out_mode(out_mode), .pwm_out(pwm_out), .count(count),
        .at_top(at_top), .at_bottom(at_bottom)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int tri_wave(input int k, input int top);
        int m = k % (2 * top);
        return (m <= top) ? m : 2 * top - m;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        load_at_bottom = 1'b0; top_from_a = 1'b0; out_mode = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R11: reset state and idle with no tick
    task automatic t_reset_idle();
        do_reset();
        check(count == 0, "R11 count", count, 0);
        check(pwm_out == 0 && !at_top && !at_bottom, "R11 outputs", {pwm_out, at_top, at_bottom}, 0);
        wr(2'd0, 16'd5);
        repeat (4) @(negedge clk);
        check(count == 0, "R11 idle hold", count, 0);
    endtask

    // R1 R2 R3 R10 triangle, duty, flags, tick gating; R5 ignored select 3
    task automatic t_triangle();
        int hi0 = 0, hi1 = 0, cbad = 0, fbad = 0;
        do_reset();
        out_mode = {2'd3, 2'd2};
        wr(2'd0, 16'd5); wr(2'd1, 16'd2); wr(2'd2, 16'd2); wr(2'd3, 16'd1);
        @(negedge clk);
        tick = 1'b1;
        for (int k = 1; k <= 29; k++) begin
            @(negedge clk);
            if (count != tri_wave(k, 5)) begin
                cbad++;
                check(0, "R1 count", count, tri_wave(k, 5));
            end
            if (at_top != (tri_wave(k, 5) == 5) || at_bottom != (k % 10 == 0)) begin
                fbad++;
                check(0, "R10 flags", {at_top, at_bottom}, k);
            end
            if (k >= 10) begin
                hi0 += pwm_out[0];
                hi1 += pwm_out[1];
            end
        end
        check(cbad == 0, "R1 triangle sequence", cbad, 0);
        check(fbad == 0, "R10 flag pulses", fbad, 0);
        check(hi0 == 8, "R2 non-inverting duty", hi0, 8);
        check(hi1 == 12, "R3 inverting duty", hi1, 12);
        tick = 1'b0;
        repeat (5) @(negedge clk);
        check(count == 1 && !at_bottom, "R1 frozen without tick", count, 1);
        tick = 1'b1;
        @(negedge clk);
        check(count == 0 && at_bottom, "R10 bottom after resume", count, 0);
    endtask

    // R4 extreme compare values
    task automatic t_extreme(input int c0, input int c1, input int e0, input int e1);
        int hi0 = 0, hi1 = 0;
        do_reset();
        out_mode = {2'd3, 2'd2};
        wr(2'd0, 16'd5); wr(2'd1, 16'(c0)); wr(2'd2, 16'(c1));
        @(negedge clk);
        tick = 1'b1;
        for (int k = 1; k <= 29; k++) begin
            @(negedge clk);
            if (k >= 10) begin
                hi0 += pwm_out[0];
                hi1 += pwm_out[1];
            end
        end
        check(hi0 == e0, "R4 non-inverting extreme", hi0, e0);
        check(hi1 == e1, "R4 inverting extreme", hi1, e1);
    endtask

    // R5 R6: load leaving TOP
    task automatic t_load_top();
        do_reset();
        out_mode = 4'b0010;
        wr(2'd0, 16'd5); wr(2'd1, 16'd0);
        @(negedge clk);
        tick = 1'b1;
        for (int k = 1; k <= 22; k++) begin
            @(negedge clk);
            if (k == 2) begin wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'd8; end
            if (k == 3) begin wr_sel = 2'd1; wr_data = 16'd4; end
            if (k == 4) wr_en = 1'b0;
            if (k == 5) begin
                check(count == 5 && at_top, "R5 old TOP until load", count, 5);
                check(pwm_out[0] == 0, "R5 old compare until load", pwm_out[0], 0);
            end
            if (k == 6)  check(count == 4, "R6 turn at old TOP", count, 4);
            if (k == 10) check(count == 0, "R6 bottom", count, 0);
            if (k == 18) check(count == 8 && at_top, "R6 new TOP", count, 8);
            if (k == 19) check(count == 7, "R6 turn at new TOP", count, 7);
            if (k == 21) check(pwm_out[0] == 0, "R6 new compare low", pwm_out[0], 0);
            if (k == 22) check(pwm_out[0] == 1, "R6 new compare sets", pwm_out[0], 1);
        end
    endtask

    // R7: load leaving zero
    task automatic t_load_bottom();
        do_reset();
        load_at_bottom = 1'b1;
        wr(2'd0, 16'd5);
        @(negedge clk);
        tick = 1'b1;
        for (int k = 1; k <= 26; k++) begin
            @(negedge clk);
            if (k == 2) begin wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'd8; end
            if (k == 3) wr_en = 1'b0;
            if (k == 6)  check(count == 4, "R7 no load at TOP", count, 4);
            if (k == 10) check(count == 0 && at_bottom, "R7 bottom", count, 0);
            if (k == 15) check(count == 5, "R7 climbs past old TOP", count, 5);
            if (k == 18) check(count == 8 && at_top, "R7 new TOP", count, 8);
            if (k == 26) check(count == 0 && at_bottom, "R7 equal slopes", count, 0);
        end
    endtask

    // R8 R9: TOP from channel A and toggle mode
    task automatic t_toggle();
        int cbad = 0, p1 = 0;
        do_reset();
        top_from_a = 1'b1;
        out_mode = {2'd1, 2'd1};
        wr(2'd0, 16'd9); wr(2'd1, 16'd4); wr(2'd2, 16'd2);
        @(negedge clk);
        tick = 1'b1;
        for (int k = 1; k <= 24; k++) begin
            @(negedge clk);
            if (count != tri_wave(k, 4)) cbad++;
            p1 += pwm_out[1];
            if (k == 3)  check(pwm_out[0] == 0, "R9 before first toggle", pwm_out[0], 0);
            if (k == 4)  check(pwm_out[0] == 1, "R9 toggle at TOP", pwm_out[0], 1);
            if (k == 11) check(pwm_out[0] == 1, "R9 hold between toggles", pwm_out[0], 1);
            if (k == 12) check(pwm_out[0] == 0, "R9 second toggle", pwm_out[0], 0);
        end
        check(cbad == 0, "R8 TOP from channel A", cbad, 0);
        check(p1 == 0, "R9 toggle ignored off channel A", p1, 0);
    endtask

    // R8: TOP floor of 3
    task automatic t_floor();
        do_reset();
        wr(2'd0, 16'd1);
        @(negedge clk);
        tick = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (k == 3) check(count == 3 && at_top, "R8 floor peak", count, 3);
            if (k == 4) check(count == 2, "R8 floor turn", count, 2);
            if (k == 6) check(count == 0, "R8 floor bottom", count, 0);
        end
    endtask

    // R9: mode 0 holds last level
    task automatic t_hold();
        int lo = 0;
        do_reset();
        out_mode = 4'b0010;
        wr(2'd0, 16'd5); wr(2'd1, 16'd2);
        @(negedge clk);
        tick = 1'b1;
        repeat (19) @(negedge clk);
        check(pwm_out[0] == 1, "R2 high before hold", pwm_out[0], 1);
        out_mode = 4'b0000;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (pwm_out[0] != 1) lo++;
        end
        check(lo == 0, "R9 mode 0 holds level", lo, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            nvec++; nbad++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        t_reset_idle();
        t_triangle();
        t_extreme(0, 0, 0, 20);
        t_extreme(5, 7, 20, 0);
        t_load_top();
        t_load_bottom();
        t_toggle();
        t_floor();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule